// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general-purpose registers of a processor whose visible register set depends on its operating mode. Logical register numbers 0 to 14 are presented on two combinational read ports and one clocked write port. The 5-bit mode field of the current status word picks the physical copy behind each number. A separate port pair reads and writes the saved status word that belongs to the current mode. The program counter and the live status word are held elsewhere and are not part of this block.

User and System mode share one set of fifteen registers, and neither has a saved status word. Each exception mode (FIQ, IRQ, Supervisor, Abort, Undefined) has a private stack pointer (logical 13), a private link register (logical 14) and a private saved status word. FIQ mode also has private copies of logical 8 to 12. A second write path is addressed by a mode code rather than by the current mode. The exception-entry sequencer uses it to load the target mode's link register and saved status word in the same cycle that the mode field switches.

The mode decode is a unique case over the mode codes and yields one of six bank selections: USR (shared by User, System and every unrecognised code), FIQ, IRQ, SVC, ABT and UND. The block has no sequential control states. The only transition is the clock edge, on which the enabled writes land.

Top module: `banked_regfile`

## Requirements
- R1: While reset (active-low, asynchronous) is held, every register and saved status word clears to zero, so all read ports return zero in every mode.
- R2: Mode codes are 5'h10 User, 5'h11 FIQ, 5'h12 IRQ, 5'h13 Supervisor, 5'h17 Abort, 5'h1B Undefined and 5'h1F System. In User and System mode, logical registers 0 to 14 address the same fifteen shared copies.
- R3: In each exception mode, logical 13 and 14 address copies that are private to that mode and start at zero after reset.
- R4: In FIQ mode, logical 8 to 12 address private copies, so writing them there never alters the shared copies. In the other exception modes, logical 0 to 12 address the shared copies.
- R5: In an exception mode, the saved-status write port stores into that mode's own saved status word, and the saved-status read port returns it. Each mode's word is independent of the others.
- R6: In User or System mode, the saved-status read returns zero and a saved-status write changes nothing.
- R7: Both read ports are combinational and independent. Writes take effect at the rising clock edge. A read of the register being written in the same cycle returns the old value.
- R8: Logical index 15 is not held here: reading it returns zero and writing it changes no register.
- R9: The named-bank path writes the link register and the saved status word of the mode given by its own mode code, whatever the current mode is. If that code selects User or System, the link write lands in the shared logical 14 and the saved-status write is dropped.
- R10: When the named-bank path and the normal port write the same physical register (or the same saved status word) in one cycle, the named-bank value is stored.
- R11: Any mode code not listed in R2 is treated as User: shared registers, no saved status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_mode | input | 5 | Mode field of the current status word |
| rd_a_idx | input | 4 | Logical register number, read port A |
| rd_a_data | output | DATA_W | Read data, port A |
| rd_b_idx | input | 4 | Logical register number, read port B |
| rd_b_data | output | DATA_W | Read data, port B |
| wr_en | input | 1 | Write enable, normal port |
| wr_idx | input | 4 | Logical register number to write |
| wr_data | input | DATA_W | Write data, normal port |
| spsr_rd_data | output | DATA_W | Saved status word of the current mode |
| spsr_wr_en | input | 1 | Saved-status write enable, current mode |
| spsr_wr_data | input | DATA_W | Saved-status write data, current mode |
| bank_wr_mode | input | 5 | Mode code addressed by the named-bank path |
| bank_lr_wr_en | input | 1 | Write that mode's link register |
| bank_lr_data | input | DATA_W | Link register value for the named bank |
| bank_spsr_wr_en | input | 1 | Write that mode's saved status word |
| bank_spsr_data | input | DATA_W | Saved status value for the named bank |

## Verification
The bench targets the aliasing boundaries first. If FIQ mapping started at 9 instead of 8, a FIQ write to logical 8 would show up in User mode. If System mode were given its own link register, a User write to logical 14 would not be visible in System mode. If the stack pointers were mapped to one shared copy, one exception mode's stack pointer would show another mode's value. The named-bank path is exercised while the current mode is different from the target, and again in a collision with a normal write to the same register: a wrong priority leaves the normal value in the link register. The bench also checks that the saved-status write is dropped in User mode, that index 15 is inert, and that a read in the write cycle returns the old value. A design that forwarded write data to the read port would fail that last check.

// File: rtl/bank_pkg.sv
package bank_pkg;

    localparam int MODE_W     = 5;
    localparam int LIDX_W     = 4;
    localparam int NUM_LOG    = 15;
    localparam int FIQ_LO     = 8;
    localparam int SP_IDX     = 13;
    localparam int NUM_FIQ_BK = NUM_LOG - FIQ_LO;
    localparam int NUM_EXC_BK = NUM_LOG - SP_IDX;
    localparam int NUM_SMALL  = 4;
    localparam int FIQ_BASE   = NUM_LOG;
    localparam int SMALL_BASE = FIQ_BASE + NUM_FIQ_BK;
    localparam int NUM_PHYS   = SMALL_BASE + NUM_SMALL * NUM_EXC_BK;
    localparam int PIDX_W     = $clog2(NUM_PHYS);
    localparam int NUM_SPSR   = 1 + NUM_SMALL;
    localparam int SIDX_W     = $clog2(NUM_SPSR);

    localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    function automatic logic [PIDX_W-1:0] small_base(input bank_e bk);
        logic [PIDX_W-1:0] step;
        step = PIDX_W'(bk) - PIDX_W'(BK_IRQ);
        return PIDX_W'(SMALL_BASE) + PIDX_W'(NUM_EXC_BK) * step;
    endfunction

endpackage

// File: rtl/bk_mode_decode.sv
module bk_mode_decode
    import bank_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_e             bank,
    output logic              has_spsr
);

    always_comb begin
        unique case (mode)
            MODE_FIQ: bank = BK_FIQ;
            MODE_IRQ: bank = BK_IRQ;
            MODE_SVC: bank = BK_SVC;
            MODE_ABT: bank = BK_ABT;
            MODE_UND: bank = BK_UND;
            MODE_USR,
            MODE_SYS: bank = BK_USR;
            default:  bank = BK_USR;
        endcase
        has_spsr = (bank != BK_USR);
    end

endmodule

// File: rtl/bk_addr_map.sv
module bk_addr_map
    import bank_pkg::*;
(
    input  bank_e             bank,
    input  logic [LIDX_W-1:0] lidx,
    output logic [PIDX_W-1:0] pidx,
    output logic              valid
);

    always_comb begin
        valid = (lidx < LIDX_W'(NUM_LOG));
        pidx  = PIDX_W'(lidx);
        unique case (bank)
            BK_FIQ: begin
                if (lidx >= LIDX_W'(FIQ_LO) && valid)
                    pidx = PIDX_W'(FIQ_BASE) + PIDX_W'(lidx - LIDX_W'(FIQ_LO));
            end
            BK_IRQ, BK_SVC, BK_ABT, BK_UND: begin
                if (lidx >= LIDX_W'(SP_IDX) && valid)
                    pidx = small_base(bank) + PIDX_W'(lidx - LIDX_W'(SP_IDX));
            end
            default: begin
                pidx = PIDX_W'(lidx);
            end
        endcase
    end

endmodule

// File: rtl/bk_store.sv
module bk_store #(
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 30,
    parameter int NUM_RD  = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data,
    input  logic                           a_en,
    input  logic [IDX_W-1:0]               a_idx,
    input  logic [DATA_W-1:0]              a_data,
    input  logic                           b_en,
    input  logic [IDX_W-1:0]               b_idx,
    input  logic [DATA_W-1:0]              b_data
);

    logic [ENTRIES-1:0][DATA_W-1:0] cells;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[e] <= '0;
            end else if (b_en && b_idx == IDX_W'(e)) begin
                cells[e] <= b_data;
            end else if (a_en && a_idx == IDX_W'(e)) begin
                cells[e] <= a_data;
            end
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            rd_data[p] = '0;
            if (int'(rd_idx[p]) < ENTRIES)
                rd_data[p] = cells[rd_idx[p]];
        end
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [4:0]           cur_mode,
    input  logic [3:0]           rd_a_idx,
    output logic [DATA_W-1:0]    rd_a_data,
    input  logic [3:0]           rd_b_idx,
    output logic [DATA_W-1:0]    rd_b_data,
    input  logic                 wr_en,
    input  logic [3:0]           wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    spsr_rd_data,
    input  logic                 spsr_wr_en,
    input  logic [DATA_W-1:0]    spsr_wr_data,
    input  logic [4:0]           bank_wr_mode,
    input  logic                 bank_lr_wr_en,
    input  logic [DATA_W-1:0]    bank_lr_data,
    input  logic                 bank_spsr_wr_en,
    input  logic [DATA_W-1:0]    bank_spsr_data
);

    localparam int NUM_RD = 2;

    bank_e cur_bank, tgt_bank;
    logic  cur_has_spsr, tgt_has_spsr;

    bk_mode_decode u_cur_dec (
        .mode     (cur_mode),
        .bank     (cur_bank),
        .has_spsr (cur_has_spsr)
    );

    bk_mode_decode u_tgt_dec (
        .mode     (bank_wr_mode),
        .bank     (tgt_bank),
        .has_spsr (tgt_has_spsr)
    );

    logic [NUM_RD-1:0][LIDX_W-1:0] rd_lidx;
    logic [NUM_RD-1:0][PIDX_W-1:0] rd_pidx;
    logic [NUM_RD-1:0]             rd_valid;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_raw;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_out;

    assign rd_lidx[0] = rd_a_idx;
    assign rd_lidx[1] = rd_b_idx;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rmap
        bk_addr_map u_map (
            .bank  (cur_bank),
            .lidx  (rd_lidx[p]),
            .pidx  (rd_pidx[p]),
            .valid (rd_valid[p])
        );
        assign rd_out[p] = rd_valid[p] ? rd_raw[p] : '0;
    end

    assign rd_a_data = rd_out[0];
    assign rd_b_data = rd_out[1];

    logic [PIDX_W-1:0] wr_pidx, lr_pidx;
    logic              wr_valid, lr_valid;

    bk_addr_map u_wmap (
        .bank  (cur_bank),
        .lidx  (wr_idx),
        .pidx  (wr_pidx),
        .valid (wr_valid)
    );

    bk_addr_map u_lrmap (
        .bank  (tgt_bank),
        .lidx  (LIDX_W'(SP_IDX + 1)),
        .pidx  (lr_pidx),
        .valid (lr_valid)
    );

    bk_store #(
        .DATA_W  (DATA_W),
        .ENTRIES (NUM_PHYS),
        .NUM_RD  (NUM_RD)
    ) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_pidx),
        .rd_data (rd_raw),
        .a_en    (wr_en && wr_valid),
        .a_idx   (wr_pidx),
        .a_data  (wr_data),
        .b_en    (bank_lr_wr_en && lr_valid),
        .b_idx   (lr_pidx),
        .b_data  (bank_lr_data)
    );

    logic [0:0][SIDX_W-1:0] sp_rd_idx;
    logic [0:0][DATA_W-1:0] sp_raw;
    logic [SIDX_W-1:0]      sp_tgt_idx;

    assign sp_rd_idx[0] = SIDX_W'(cur_bank) - SIDX_W'(1);
    assign sp_tgt_idx   = SIDX_W'(tgt_bank) - SIDX_W'(1);

    bk_store #(
        .DATA_W  (DATA_W),
        .ENTRIES (NUM_SPSR),
        .NUM_RD  (1)
    ) u_spsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (sp_rd_idx),
        .rd_data (sp_raw),
        .a_en    (spsr_wr_en && cur_has_spsr),
        .a_idx   (sp_rd_idx[0]),
        .a_data  (spsr_wr_data),
        .b_en    (bank_spsr_wr_en && tgt_has_spsr),
        .b_idx   (sp_tgt_idx),
        .b_data  (bank_spsr_data)
    );

    assign spsr_rd_data = cur_has_spsr ? sp_raw[0] : '0;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        cur_mode,
    input logic [3:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [3:0]        rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] spsr_rd_data,
    input logic              spsr_wr_en,
    input logic [DATA_W-1:0] spsr_wr_data,
    input logic [4:0]        bank_wr_mode,
    input logic              bank_lr_wr_en,
    input logic [DATA_W-1:0] bank_lr_data,
    input logic              bank_spsr_wr_en,
    input logic [DATA_W-1:0] bank_spsr_data
);

    function automatic logic is_exc(input logic [4:0] m);
        return (m == 5'h11) || (m == 5'h12) || (m == 5'h13) ||
               (m == 5'h17) || (m == 5'h1B);
    endfunction

    // R1: a second edge under reset shows every read port at zero
    p_reset_clear_r1: assert property (@(posedge clk)
        (!rst_n) |=> (rst_n || (rd_a_data == '0 && rd_b_data == '0 && spsr_rd_data == '0)));

    // R6 / R11: no saved status word outside the exception modes
    p_spsr_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_exc(cur_mode)) |-> (spsr_rd_data == '0));

    // R8: index 15 reads as zero on both ports
    p_idx15_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 4'd15) |-> (rd_a_data == '0));
    p_idx15_zero_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == 4'd15) |-> (rd_b_data == '0));

    // R7: a normal write is visible one edge later in the same mode
    p_write_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != 4'd15 && !bank_lr_wr_en) |=>
        (cur_mode != $past(cur_mode) || rd_a_idx != $past(wr_idx) ||
         rd_a_data == $past(wr_data)));

    // R5: saved-status write in an exception mode reads back
    p_spsr_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spsr_wr_en && is_exc(cur_mode) && !bank_spsr_wr_en) |=>
        (cur_mode != $past(cur_mode) || spsr_rd_data == $past(spsr_wr_data)));

    // R9: named-bank link write lands in the named mode's logical 14
    p_bank_lr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bank_lr_wr_en |=>
        (cur_mode != $past(bank_wr_mode) || rd_b_idx != 4'd14 ||
         rd_b_data == $past(bank_lr_data)));

    // R10: named-bank saved-status write wins over the normal one
    p_bank_spsr_win_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_spsr_wr_en && is_exc(bank_wr_mode)) |=>
        (cur_mode != $past(bank_wr_mode) || spsr_rd_data == $past(bank_spsr_data)));

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cur_mode        (cur_mode),
    .rd_a_idx        (rd_a_idx),
    .rd_a_data       (rd_a_data),
    .rd_b_idx        (rd_b_idx),
    .rd_b_data       (rd_b_data),
    .wr_en           (wr_en),
    .wr_idx          (wr_idx),
    .wr_data         (wr_data),
    .spsr_rd_data    (spsr_rd_data),
    .spsr_wr_en      (spsr_wr_en),
    .spsr_wr_data    (spsr_wr_data),
    .bank_wr_mode    (bank_wr_mode),
    .bank_lr_wr_en   (bank_lr_wr_en),
    .bank_lr_data    (bank_lr_data),
    .bank_spsr_wr_en (bank_spsr_wr_en),
    .bank_spsr_data  (bank_spsr_data)
);

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;

    localparam int DW = 32;
    localparam logic [4:0] M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12,
                           M_SVC = 5'h13, M_ABT = 5'h17, M_UND = 5'h1B,
                           M_SYS = 5'h1F, M_BAD = 5'h00;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    cur_mode = M_USR;
    logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, spsr_rd_data;
    logic          wr_en = 1'b0, spsr_wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0, spsr_wr_data = '0;
    logic [4:0]    bank_wr_mode = M_USR;
    logic          bank_lr_wr_en = 1'b0, bank_spsr_wr_en = 1'b0;
    logic [DW-1:0] bank_lr_data = '0, bank_spsr_data = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    banked_regfile #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .spsr_rd_data(spsr_rd_data), .spsr_wr_en(spsr_wr_en),
        .spsr_wr_data(spsr_wr_data), .bank_wr_mode(bank_wr_mode),
        .bank_lr_wr_en(bank_lr_wr_en), .bank_lr_data(bank_lr_data),
        .bank_spsr_wr_en(bank_spsr_wr_en), .bank_spsr_data(bank_spsr_data)
    );

    typedef struct packed {
        logic          is_rd;
        logic [4:0]    mode;
        logic [3:0]    idx;
        logic [DW-1:0] val;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b0, M_USR, 4'd0,  32'hA000_0000},
        '{1'b0, M_USR, 4'd8,  32'hA000_0008},
        '{1'b0, M_USR, 4'd13, 32'hA000_000D},
        '{1'b0, M_USR, 4'd14, 32'hA000_000E},
        '{1'b0, M_FIQ, 4'd8,  32'hF000_0008},
        '{1'b0, M_FIQ, 4'd12, 32'hF000_000C},
        '{1'b0, M_FIQ, 4'd13, 32'hF000_000D},
        '{1'b0, M_IRQ, 4'd13, 32'hB000_000D},
        '{1'b0, M_IRQ, 4'd14, 32'hB000_000E},
        '{1'b0, M_IRQ, 4'd3,  32'h3333_3333},
        '{1'b0, M_SVC, 4'd13, 32'hC000_000D},
        '{1'b0, M_ABT, 4'd13, 32'hD000_000D},
        '{1'b0, M_UND, 4'd14, 32'hE000_000E},
        '{1'b1, M_USR, 4'd8,  32'hA000_0008},   // R4 shared copy untouched by FIQ
        '{1'b1, M_FIQ, 4'd8,  32'hF000_0008},   // R4 FIQ private 8
        '{1'b1, M_FIQ, 4'd12, 32'hF000_000C},   // R4 FIQ private 12
        '{1'b1, M_FIQ, 4'd9,  32'h0000_0000},   // R4 FIQ private 9 unwritten
        '{1'b1, M_SYS, 4'd13, 32'hA000_000D},   // R2 System = User SP
        '{1'b1, M_SYS, 4'd14, 32'hA000_000E},   // R2 System = User LR
        '{1'b1, M_IRQ, 4'd13, 32'hB000_000D},   // R3
        '{1'b1, M_SVC, 4'd13, 32'hC000_000D},   // R3
        '{1'b1, M_ABT, 4'd13, 32'hD000_000D},   // R3
        '{1'b1, M_UND, 4'd14, 32'hE000_000E},   // R3
        '{1'b1, M_UND, 4'd13, 32'h0000_0000},   // R3 unwritten private SP
        '{1'b1, M_FIQ, 4'd14, 32'h0000_0000},   // R3 unwritten private LR
        '{1'b1, M_USR, 4'd3,  32'h3333_3333},   // R4 IRQ write to 3 is shared
        '{1'b1, M_IRQ, 4'd8,  32'hA000_0008},   // R4 IRQ sees shared 8
        '{1'b1, M_BAD, 4'd13, 32'hA000_000D}    // R11 unknown code acts as User
    };

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] m, input logic [3:0] i, input logic [DW-1:0] d);
        @(negedge clk);
        cur_mode = m; wr_idx = i; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_a(input logic [4:0] m, input logic [3:0] i, output logic [DW-1:0] d);
        @(negedge clk);
        cur_mode = m; rd_a_idx = i;
        #1 d = rd_a_data;
    endtask

    task automatic rd_spsr(input logic [4:0] m, output logic [DW-1:0] d);
        @(negedge clk);
        cur_mode = m;
        #1 d = spsr_rd_data;
    endtask

    task automatic spsr_write(input logic [4:0] m, input logic [DW-1:0] d);
        @(negedge clk);
        cur_mode = m; spsr_wr_data = d; spsr_wr_en = 1'b1;
        @(negedge clk);
        spsr_wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got %h expected %h", 32'h1, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(posedge clk);

        // R1: reset state seen in several modes
        rd_a(M_USR, 4'd0, d);  chk("R1 user r0 after reset", d, '0);
        rd_a(M_FIQ, 4'd14, d); chk("R1 fiq r14 after reset", d, '0);
        rd_spsr(M_SVC, d);     chk("R1 svc spsr after reset", d, '0);

        @(negedge clk) rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            if (!VECS[v].is_rd) begin
                do_write(VECS[v].mode, VECS[v].idx, VECS[v].val);
            end else begin
                @(negedge clk);
                cur_mode = VECS[v].mode;
                rd_a_idx = VECS[v].idx;
                rd_b_idx = VECS[v].idx;
                #1;
                chk($sformatf("vector %0d port A (R2 R3 R4 R11)", v), rd_a_data, VECS[v].val);
                chk($sformatf("vector %0d port B (R7)", v), rd_b_data, VECS[v].val);
            end
        end

        // R7: independent ports and old value in the write cycle
        @(negedge clk);
        cur_mode = M_USR; rd_a_idx = 4'd0; rd_b_idx = 4'd3;
        wr_idx = 4'd0; wr_data = 32'h5555_AAAA; wr_en = 1'b1;
        #1;
        chk("R7 same-cycle read old value", rd_a_data, 32'hA000_0000);
        chk("R7 port B independent", rd_b_data, 32'h3333_3333);
        @(posedge clk); #1;
        chk("R7 new value after edge", rd_a_data, 32'h5555_AAAA);
        @(negedge clk) wr_en = 1'b0;

        // R8: index 15 inert
        do_write(M_USR, 4'd15, 32'hDEAD_BEEF);
        rd_a(M_USR, 4'd15, d); chk("R8 idx15 reads zero", d, '0);
        rd_a(M_USR, 4'd14, d); chk("R8 r14 unchanged by idx15 write", d, 32'hA000_000E);
        rd_a(M_USR, 4'd0, d);  chk("R8 r0 unchanged by idx15 write", d, 32'h5555_AAAA);

        // R5: per-mode saved status words
        spsr_write(M_SVC, 32'h0000_00D3);
        spsr_write(M_IRQ, 32'h0000_0092);
        rd_spsr(M_SVC, d); chk("R5 svc spsr", d, 32'h0000_00D3);
        rd_spsr(M_IRQ, d); chk("R5 irq spsr", d, 32'h0000_0092);
        rd_spsr(M_ABT, d); chk("R5 abt spsr untouched", d, '0);

        // R6: user/system saved status inert
        spsr_write(M_USR, 32'h1234_5678);
        spsr_write(M_SYS, 32'h8765_4321);
        rd_spsr(M_USR, d); chk("R6 user spsr reads zero", d, '0);
        rd_spsr(M_SYS, d); chk("R6 system spsr reads zero", d, '0);
        rd_spsr(M_SVC, d); chk("R6 svc spsr unchanged", d, 32'h0000_00D3);
        rd_spsr(M_BAD, d); chk("R11 unknown mode spsr zero", d, '0);

        // R9: named-bank write while in User mode
        @(negedge clk);
        cur_mode = M_USR; bank_wr_mode = M_ABT;
        bank_lr_data = 32'h0000_4004; bank_lr_wr_en = 1'b1;
        bank_spsr_data = 32'h0000_0010; bank_spsr_wr_en = 1'b1;
        @(negedge clk);
        bank_lr_wr_en = 1'b0; bank_spsr_wr_en = 1'b0;
        rd_a(M_ABT, 4'd14, d); chk("R9 abort lr via named bank", d, 32'h0000_4004);
        rd_spsr(M_ABT, d);     chk("R9 abort spsr via named bank", d, 32'h0000_0010);
        rd_a(M_USR, 4'd14, d); chk("R9 user lr untouched", d, 32'hA000_000E);

        // R9: named bank = System; lr goes to shared, spsr dropped
        @(negedge clk);
        cur_mode = M_SVC; bank_wr_mode = M_SYS;
        bank_lr_data = 32'h0000_7777; bank_lr_wr_en = 1'b1;
        bank_spsr_data = 32'hFFFF_0000; bank_spsr_wr_en = 1'b1;
        @(negedge clk);
        bank_lr_wr_en = 1'b0; bank_spsr_wr_en = 1'b0;
        rd_a(M_USR, 4'd14, d); chk("R9 system target lr shared", d, 32'h0000_7777);
        rd_spsr(M_SVC, d);     chk("R9 system target spsr dropped", d, 32'h0000_00D3);

        // R10: collision, named bank wins
        @(negedge clk);
        cur_mode = M_UND; bank_wr_mode = M_UND;
        wr_idx = 4'd14; wr_data = 32'h1111_1111; wr_en = 1'b1;
        spsr_wr_data = 32'h2222_2222; spsr_wr_en = 1'b1;
        bank_lr_data = 32'h0000_9999; bank_lr_wr_en = 1'b1;
        bank_spsr_data = 32'h0000_001B; bank_spsr_wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; spsr_wr_en = 1'b0; bank_lr_wr_en = 1'b0; bank_spsr_wr_en = 1'b0;
        rd_a(M_UND, 4'd14, d); chk("R10 lr collision named wins", d, 32'h0000_9999);
        rd_spsr(M_UND, d);     chk("R10 spsr collision named wins", d, 32'h0000_001B);

        // R1: reset mid-run clears written state
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        rd_a(M_IRQ, 4'd13, d); chk("R1 irq sp cleared", d, '0);
        rd_a(M_USR, 4'd3, d);  chk("R1 user r3 cleared", d, '0);
        rd_spsr(M_UND, d);     chk("R1 und spsr cleared", d, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule